// File: doc/BRIEF.md
# Secure-Aware Exception Entry Controller

This block computes the architectural state a processor core writes when it takes an exception. Each cycle it looks at eight exception request lines and picks one. The lines are reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ, FIQ and secure monitor call. For the winning request it produces:

- the new status word;
- the saved copy of the old status word;
- the link value;
- the target mode;
- the branch address;
- a pulse that clears the non-secure (NS) bit.

The pipeline uses these values to redirect fetch and to load the banked registers. The block does not decode instructions, flush the pipeline or hold the register file.

The security world decides which vector table is used. When the NS bit is clear, or the core is already in monitor mode, the world is secure and the secure base applies; otherwise the non-secure base applies. Three secure configuration bits can send IRQ, FIQ or aborts to monitor mode instead. Two further bits can stop the non-secure world from setting the FIQ-mask and abort-mask bits. Every request line, configuration pin and output is a plain level signal. There is no handshake: a request is taken in the cycle it is seen. A request that loses arbitration must be held by its source until it wins.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A reset request enters supervisor mode (mode 5'b10011). It branches to 0xFFFF0000 when `hivec_i` is 1 and to 0x00000000 otherwise. It pulses `ns_clr_o`, and drives `spsr_o` and `lr_o` to zero.
- R2: A monitor call enters mode 5'b10110 and branches to `mon_base_i` + 0x8, ignoring `hivec_i`. For every entry other than reset, `lr_o` is `instr_addr_i` + 4 and `spsr_o` is `cur_psr_i`.
- R3: The new status word is `cur_psr_i` with these changes:
  - bits [4:0] hold the target mode;
  - bit 5 is cleared;
  - bit 7 is set;
  - bit 9 is taken from `sec_ee_i`;
  - bit 24 is cleared.
  
  All other bits except 6 and 8 are copied unchanged.
- R4: Status bit 6 (FIQ mask) and bit 8 (abort mask) are normally set on entry. In one case they can instead keep their old value: the world is non-secure, the target is not monitor mode, and the entry is not reset. In that case bit 6 keeps its old value when `sec_cfg_i[4]` is 1, and bit 8 keeps its old value when `sec_cfg_i[5]` is 1.
- R5: The world is secure when `sec_cfg_i[0]` (NS) is 0 or `cur_psr_i[4:0]` is 5'b10110. For an entry not routed to monitor mode, the base is chosen as follows:
  - 0xFFFF0000 when `hivec_i` is 1;
  - otherwise `sec_base_i` in the secure world and `ns_base_i` in the non-secure world.
  
  The branch address is that base plus the vector offset.
- R6: Each entry has a vector offset and a target mode:

  | Entry | Offset | Mode |
  |---|---|---|
  | Undefined instruction | 0x04 | 5'b11011 |
  | Software interrupt | 0x08 | 5'b10011 |
  | Prefetch abort | 0x0C | 5'b10111 |
  | Data abort | 0x10 | 5'b10111 |
  | IRQ | 0x18 | 5'b10010 |
  | FIQ | 0x1C | 5'b10001 |
  | Reset | 0x00 | see R1 |

  `mode_o` equals the new status bits [4:0].
- R7: The following entries go to monitor mode 5'b10110 and branch to `mon_base_i` plus the same offset:
  - IRQ when `sec_cfg_i[1]` is 1;
  - FIQ when `sec_cfg_i[2]` is 1;
  - either abort when `sec_cfg_i[3]` is 1.
  
  Otherwise these entries use their R6 mode and the R5 base.
- R8: `ns_clr_o` pulses with the entry when the entry is reset or when `cur_psr_i[4:0]` is 5'b10110. Otherwise it stays 0.
- R9: When several requests are present, they are served in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt, monitor call. Exactly one entry is taken per cycle.
- R10: All results appear on the clock edge after a request is sampled, together with a one-cycle `taken_o`. In a cycle with no request, `taken_o` is 0 and the other outputs keep their values.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req_i | input | 1 | Reset exception request |
| und_req_i | input | 1 | Undefined instruction request |
| swi_req_i | input | 1 | Software interrupt request |
| pabt_req_i | input | 1 | Prefetch abort request |
| dabt_req_i | input | 1 | Data abort request |
| irq_req_i | input | 1 | IRQ request |
| fiq_req_i | input | 1 | FIQ request |
| smc_req_i | input | 1 | Secure monitor call request |
| instr_addr_i | input | 32 | Address of the instruction causing the entry |
| cur_psr_i | input | 32 | Current status word |
| sec_cfg_i | input | 6 | [0] NS, [1] IRQ to monitor, [2] FIQ to monitor, [3] abort to monitor, [4] FIQ mask locked, [5] abort mask locked |
| sec_ee_i | input | 1 | Endianness bit from the secure control register |
| hivec_i | input | 1 | High vector table select |
| sec_base_i | input | 32 | Secure vector base |
| ns_base_i | input | 32 | Non-secure vector base |
| mon_base_i | input | 32 | Monitor vector base |
| taken_o | output | 1 | One-cycle entry pulse |
| mode_o | output | 5 | Target mode |
| psr_o | output | 32 | New status word |
| spsr_o | output | 32 | Saved status word |
| lr_o | output | 32 | Link value |
| pc_o | output | 32 | Branch address |
| ns_clr_o | output | 1 | Clear NS bit pulse |

## Verification
Every result of this block is due exactly one rising edge after the request is sampled:

- the status word, saved status, link value, branch address, target mode and NS-clear pulse;
- `taken_o`, which is also due on that edge and falls on the following edge when no request remains.

The bench changes inputs on the falling edge. It compares all outputs at the next falling edge, which lies after exactly one rising edge. It then removes the request and, one cycle later, checks that `taken_o` has dropped and that the other outputs have held their values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int XLEN    = 32;
  localparam int MODE_W  = 5;
  localparam int NUM_EXC = 8;

  // Status word bit positions
  localparam int PSR_T_BIT  = 5;
  localparam int PSR_F_BIT  = 6;
  localparam int PSR_I_BIT  = 7;
  localparam int PSR_A_BIT  = 8;
  localparam int PSR_E_BIT  = 9;
  localparam int PSR_J_BIT  = 24;

  // Secure configuration bit positions
  localparam int CFG_NS      = 0;
  localparam int CFG_IRQ_MON = 1;
  localparam int CFG_FIQ_MON = 2;
  localparam int CFG_ABT_MON = 3;
  localparam int CFG_F_LOCK  = 4;
  localparam int CFG_A_LOCK  = 5;
  localparam int CFG_W       = 6;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  // Index order is priority order: lower index wins.
  typedef enum logic [2:0] {
    EK_RESET = 3'd0,
    EK_DABT  = 3'd1,
    EK_FIQ   = 3'd2,
    EK_IRQ   = 3'd3,
    EK_PABT  = 3'd4,
    EK_UND   = 3'd5,
    EK_SWI   = 3'd6,
    EK_SMC   = 3'd7
  } exc_kind_e;

  function automatic logic [XLEN-1:0] vec_offset(exc_kind_e k);
    case (k)
      EK_UND:  return 32'h04;
      EK_SWI:  return 32'h08;
      EK_SMC:  return 32'h08;
      EK_PABT: return 32'h0C;
      EK_DABT: return 32'h10;
      EK_IRQ:  return 32'h18;
      EK_FIQ:  return 32'h1C;
      default: return 32'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] native_mode(exc_kind_e k);
    case (k)
      EK_UND:          return MODE_UND;
      EK_PABT, EK_DABT: return MODE_ABT;
      EK_IRQ:          return MODE_IRQ;
      EK_FIQ:          return MODE_FIQ;
      EK_SMC:          return MODE_MON;
      default:         return MODE_SVC;
    endcase
  endfunction

  typedef struct packed {
    logic [XLEN-1:0]   psr;
    logic [XLEN-1:0]   spsr;
    logic [XLEN-1:0]   lr;
    logic [XLEN-1:0]   pc;
    logic [MODE_W-1:0] mode;
    logic              ns_clr;
  } entry_t;

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    // Scan from the top so the lowest set index is left in idx.
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/exc_route.sv
module exc_route
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  exc_kind_e           kind,
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic [CFG_W-1:0]    sec_cfg,
  input  logic                hivec,
  input  logic [XLEN-1:0]     sec_base,
  input  logic [XLEN-1:0]     ns_base,
  input  logic [XLEN-1:0]     mon_base,
  output logic                in_mon,
  output logic                world_secure,
  output logic                to_mon,
  output logic [MODE_W-1:0]   tgt_mode,
  output logic [XLEN-1:0]     vec_pc
);
  logic [XLEN-1:0] base;

  always_comb begin
    in_mon       = (cur_mode == MODE_MON);
    world_secure = in_mon || !sec_cfg[CFG_NS];

    case (kind)
      EK_IRQ:           to_mon = sec_cfg[CFG_IRQ_MON];
      EK_FIQ:           to_mon = sec_cfg[CFG_FIQ_MON];
      EK_PABT, EK_DABT: to_mon = sec_cfg[CFG_ABT_MON];
      EK_SMC:           to_mon = 1'b1;
      default:          to_mon = 1'b0;
    endcase

    tgt_mode = to_mon ? MODE_MON : native_mode(kind);

    if (to_mon)              base = mon_base;
    else if (hivec)          base = HIVEC_BASE;
    else if (kind == EK_RESET) base = '0;
    else if (world_secure)   base = sec_base;
    else                     base = ns_base;

    vec_pc = base + vec_offset(kind);
  end
endmodule

// File: rtl/exc_psr_build.sv
module exc_psr_build
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0]   cur_psr,
  input  exc_kind_e         kind,
  input  logic [MODE_W-1:0] tgt_mode,
  input  logic              world_secure,
  input  logic              to_mon,
  input  logic              f_lock,
  input  logic              a_lock,
  input  logic              ee,
  output logic [XLEN-1:0]   new_psr
);
  logic guarded;

  always_comb begin
    // Mask locks only bite for a non-secure, non-monitor, non-reset entry.
    guarded = !world_secure && !to_mon && (kind != EK_RESET);

    new_psr             = cur_psr;
    new_psr[MODE_W-1:0] = tgt_mode;
    new_psr[PSR_T_BIT]  = 1'b0;
    new_psr[PSR_F_BIT]  = (guarded && f_lock) ? cur_psr[PSR_F_BIT] : 1'b1;
    new_psr[PSR_I_BIT]  = 1'b1;
    new_psr[PSR_A_BIT]  = (guarded && a_lock) ? cur_psr[PSR_A_BIT] : 1'b1;
    new_psr[PSR_E_BIT]  = ee;
    new_psr[PSR_J_BIT]  = 1'b0;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000,
  parameter logic [XLEN-1:0] LINK_STEP  = 32'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req_i,
  input  logic              und_req_i,
  input  logic              swi_req_i,
  input  logic              pabt_req_i,
  input  logic              dabt_req_i,
  input  logic              irq_req_i,
  input  logic              fiq_req_i,
  input  logic              smc_req_i,
  input  logic [XLEN-1:0]   instr_addr_i,
  input  logic [XLEN-1:0]   cur_psr_i,
  input  logic [CFG_W-1:0]  sec_cfg_i,
  input  logic              sec_ee_i,
  input  logic              hivec_i,
  input  logic [XLEN-1:0]   sec_base_i,
  input  logic [XLEN-1:0]   ns_base_i,
  input  logic [XLEN-1:0]   mon_base_i,
  output logic              taken_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [XLEN-1:0]   psr_o,
  output logic [XLEN-1:0]   spsr_o,
  output logic [XLEN-1:0]   lr_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              ns_clr_o
);
  localparam int KW = $clog2(NUM_EXC);

  logic [NUM_EXC-1:0] req_vec;
  logic               any_req;
  logic [KW-1:0]      win_idx;
  exc_kind_e          kind;

  logic               in_mon, world_secure, to_mon;
  logic [MODE_W-1:0]  tgt_mode;
  logic [XLEN-1:0]    vec_pc, new_psr;
  entry_t             entry_d, entry_q;
  logic               taken_q;

  // Packed in priority order (see exc_kind_e).
  assign req_vec = {smc_req_i, swi_req_i, und_req_i, pabt_req_i,
                    irq_req_i, fiq_req_i, dabt_req_i, reset_req_i};

  exc_prio_pick #(.N(NUM_EXC)) u_pick (
    .req   (req_vec),
    .valid (any_req),
    .idx   (win_idx)
  );

  assign kind = exc_kind_e'(win_idx);

  exc_route #(.HIVEC_BASE(HIVEC_BASE)) u_route (
    .kind         (kind),
    .cur_mode     (cur_psr_i[MODE_W-1:0]),
    .sec_cfg      (sec_cfg_i),
    .hivec        (hivec_i),
    .sec_base     (sec_base_i),
    .ns_base      (ns_base_i),
    .mon_base     (mon_base_i),
    .in_mon       (in_mon),
    .world_secure (world_secure),
    .to_mon       (to_mon),
    .tgt_mode     (tgt_mode),
    .vec_pc       (vec_pc)
  );

  exc_psr_build u_psr (
    .cur_psr      (cur_psr_i),
    .kind         (kind),
    .tgt_mode     (tgt_mode),
    .world_secure (world_secure),
    .to_mon       (to_mon),
    .f_lock       (sec_cfg_i[CFG_F_LOCK]),
    .a_lock       (sec_cfg_i[CFG_A_LOCK]),
    .ee           (sec_ee_i),
    .new_psr      (new_psr)
  );

  always_comb begin
    entry_d.psr    = new_psr;
    entry_d.mode   = tgt_mode;
    entry_d.pc     = vec_pc;
    entry_d.ns_clr = (kind == EK_RESET) || in_mon;
    if (kind == EK_RESET) begin
      entry_d.spsr = '0;
      entry_d.lr   = '0;
    end else begin
      entry_d.spsr = cur_psr_i;
      entry_d.lr   = instr_addr_i + LINK_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= any_req;
      if (any_req) entry_q <= entry_d;
      else         entry_q.ns_clr <= 1'b0;
    end
  end

  assign taken_o  = taken_q;
  assign mode_o   = entry_q.mode;
  assign psr_o    = entry_q.psr;
  assign spsr_o   = entry_q.spsr;
  assign lr_o     = entry_q.lr;
  assign pc_o     = entry_q.pc;
  assign ns_clr_o = entry_q.ns_clr;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reset_req_i,
  input logic              und_req_i,
  input logic              swi_req_i,
  input logic              pabt_req_i,
  input logic              dabt_req_i,
  input logic              irq_req_i,
  input logic              fiq_req_i,
  input logic              smc_req_i,
  input logic [XLEN-1:0]   mon_base_i,
  input logic              taken_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [XLEN-1:0]   psr_o,
  input logic [XLEN-1:0]   pc_o,
  input logic              ns_clr_o
);
  logic any_req, smc_alone;
  assign any_req   = reset_req_i | und_req_i | swi_req_i | pabt_req_i |
                     dabt_req_i | irq_req_i | fiq_req_i | smc_req_i;
  assign smc_alone = smc_req_i & ~(reset_req_i | und_req_i | swi_req_i |
                     pabt_req_i | dabt_req_i | irq_req_i | fiq_req_i);

  // R10
  taken_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> taken_o);

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (!taken_o && $stable(pc_o) && $stable(psr_o)));

  // R1
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_i |=> (mode_o == MODE_SVC && ns_clr_o));

  // R2
  smc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smc_alone |=> (mode_o == MODE_MON && pc_o == $past(mon_base_i) + 32'h8));

  // R3
  status_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (!psr_o[PSR_T_BIT] && psr_o[PSR_I_BIT] && !psr_o[PSR_J_BIT]
                 && psr_o[MODE_W-1:0] == mode_o));

  // R8
  ns_clr_with_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_clr_o |-> taken_o);
endmodule

bind exc_entry_ctrl exc_entry_chk i_exc_entry_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reset_req_i (reset_req_i),
  .und_req_i   (und_req_i),
  .swi_req_i   (swi_req_i),
  .pabt_req_i  (pabt_req_i),
  .dabt_req_i  (dabt_req_i),
  .irq_req_i   (irq_req_i),
  .fiq_req_i   (fiq_req_i),
  .smc_req_i   (smc_req_i),
  .mon_base_i  (mon_base_i),
  .taken_o     (taken_o),
  .mode_o      (mode_o),
  .psr_o       (psr_o),
  .pc_o        (pc_o),
  .ns_clr_o    (ns_clr_o)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;  // bit0 reset,1 dabt,2 fiq,3 irq,4 pabt,5 und,6 swi,7 smc
  logic [31:0] instr_addr = '0, cur_psr = '0;
  logic [5:0]  sec_cfg = '0;
  logic        sec_ee = 1'b0, hivec = 1'b0;
  logic [31:0] sec_base = 32'h1000_0000, ns_base = 32'h2000_0000, mon_base = 32'h3000_0000;
  logic        taken, ns_clr;
  logic [4:0]  mode;
  logic [31:0] psr, spsr, lr, pc;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reset_req_i(req[0]), .und_req_i(req[5]), .swi_req_i(req[6]),
    .pabt_req_i(req[4]), .dabt_req_i(req[1]), .irq_req_i(req[3]),
    .fiq_req_i(req[2]), .smc_req_i(req[7]),
    .instr_addr_i(instr_addr), .cur_psr_i(cur_psr), .sec_cfg_i(sec_cfg),
    .sec_ee_i(sec_ee), .hivec_i(hivec), .sec_base_i(sec_base),
    .ns_base_i(ns_base), .mon_base_i(mon_base),
    .taken_o(taken), .mode_o(mode), .psr_o(psr), .spsr_o(spsr),
    .lr_o(lr), .pc_o(pc), .ns_clr_o(ns_clr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // Expected-value model built from the requirement text.
  logic [31:0] e_psr, e_spsr, e_lr, e_pc;
  logic [4:0]  e_mode;
  logic        e_ns_clr, e_mon;
  int          e_kind;

  task automatic model(input logic [7:0] m);
    logic secure, in_mon, guarded;
    logic [31:0] off, base;
    e_kind = 0;
    for (int i = 7; i >= 0; i--) if (m[i]) e_kind = i;   // R9 order
    in_mon = (cur_psr[4:0] == 5'b10110);
    secure = in_mon || !sec_cfg[0];
    case (e_kind)
      3: e_mon = sec_cfg[1];
      2: e_mon = sec_cfg[2];
      1, 4: e_mon = sec_cfg[3];
      7: e_mon = 1'b1;
      default: e_mon = 1'b0;
    endcase
    case (e_kind)
      0: begin off = 32'h00; e_mode = 5'b10011; end
      1: begin off = 32'h10; e_mode = 5'b10111; end
      2: begin off = 32'h1C; e_mode = 5'b10001; end
      3: begin off = 32'h18; e_mode = 5'b10010; end
      4: begin off = 32'h0C; e_mode = 5'b10111; end
      5: begin off = 32'h04; e_mode = 5'b11011; end
      6: begin off = 32'h08; e_mode = 5'b10011; end
      default: begin off = 32'h08; e_mode = 5'b10110; end
    endcase
    if (e_mon) e_mode = 5'b10110;
    if (e_mon) base = mon_base;
    else if (hivec) base = 32'hFFFF_0000;
    else if (e_kind == 0) base = 32'h0;
    else base = secure ? sec_base : ns_base;
    e_pc = base + off;
    guarded = !secure && !e_mon && (e_kind != 0);
    e_psr = cur_psr;
    e_psr[4:0] = e_mode;
    e_psr[5] = 1'b0;
    e_psr[6] = (guarded && sec_cfg[4]) ? cur_psr[6] : 1'b1;
    e_psr[7] = 1'b1;
    e_psr[8] = (guarded && sec_cfg[5]) ? cur_psr[8] : 1'b1;
    e_psr[9] = sec_ee;
    e_psr[24] = 1'b0;
    e_spsr = (e_kind == 0) ? 32'h0 : cur_psr;
    e_lr   = (e_kind == 0) ? 32'h0 : instr_addr + 32'd4;
    e_ns_clr = (e_kind == 0) || in_mon;
  endtask

  task automatic run_one(input logic [7:0] m, input string ptag);
    string tag;
    logic [31:0] hold_pc, hold_psr;
    @(negedge clk);
    req = m;
    model(m);
    if (ptag.len() != 0) tag = ptag;
    else if (e_kind == 0) tag = "R1";
    else if (e_kind == 7) tag = "R2";
    else if (e_mon) tag = "R7";
    else tag = "R5";
    @(negedge clk);  // one rising edge later
    req = '0;
    chk(taken === 1'b1, "R10", "taken", {31'b0, taken}, 32'h1);
    chk(pc === e_pc, tag, "pc", pc, e_pc);
    chk(lr === e_lr, (e_kind == 0) ? "R1" : "R2", "lr", lr, e_lr);
    chk(spsr === e_spsr, (e_kind == 0) ? "R1" : "R2", "spsr", spsr, e_spsr);
    chk(psr === e_psr, "R3 R4", "psr", psr, e_psr);
    chk(mode === e_mode, "R6", "mode", {27'b0, mode}, {27'b0, e_mode});
    chk(ns_clr === e_ns_clr, "R8", "ns_clr", {31'b0, ns_clr}, {31'b0, e_ns_clr});
    hold_pc = pc; hold_psr = psr;
    @(negedge clk);
    chk(taken === 1'b0 && ns_clr === 1'b0, "R10", "idle pulse",
        {30'b0, taken, ns_clr}, 32'h0);
    chk(pc === hold_pc && psr === hold_psr, "R10", "hold", pc, hold_pc);
  endtask

  function automatic logic [4:0] pick_mode(int i);
    case (i)
      0: return 5'b10000;
      1: return 5'b10110;
      default: return 5'b10011;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset
    chk({taken, ns_clr, mode} === '0 && psr === '0 && pc === '0 && lr === '0 && spsr === '0,
        "R11", "reset state", pc, 32'h0);
    rst_n = 1'b1;

    // R9: every request combination under one configuration
    cur_psr = 32'hF10F_0C10; sec_cfg = 6'b000001; instr_addr = 32'h0000_8000;
    for (int m = 1; m < 256; m++) run_one(8'(m), "R9");

    // Single requests over modes, worlds, configuration bits and vector select
    for (int cm = 0; cm < 3; cm++)
      for (int ns = 0; ns < 2; ns++)
        for (int cfg = 0; cfg < 32; cfg++)
          for (int hv = 0; hv < 2; hv++)
            for (int k = 0; k < 8; k++) begin
              cur_psr    = 32'hF10F_0C00 | {27'b0, pick_mode(cm)} | ((cfg & 1) ? 32'h140 : 32'h0);
              sec_cfg    = {5'(cfg), 1'(ns)};
              hivec      = 1'(hv);
              sec_ee     = 1'(cfg[1] ^ hv[0]);
              instr_addr = 32'h0004_0000 + 32'(k * 16 + cfg);
              run_one(8'(1 << k), "");
            end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule